// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

A small memory-mapped periodic timer with a parameterised number of identical channels (two by default). Each channel holds a control word, an initial count and a live count. A channel counts only while its interrupt-enable, count-enable and debug-enable bits are all set. Every cycle with `tick_i` high, the live count drops by one. A tick that arrives while the count is zero reloads it from the initial count and latches that channel's bit in a shared sticky status register. The timer period is therefore the initial count plus one tick.

The host reaches the registers through a single-cycle word bus with a combinational read path. The word address is split into a two-bit region field above a channel field (one bit by default). Region 0 holds control, region 1 the initial count, region 2 the live count, and region 3 with channel field 0 holds status. With the defaults, the word addresses are: control 0/1, initial count 2/3, live count 4/5, status 6. Each channel drives its own level interrupt line toward an interrupt controller.

Top module: `interval_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 and every `irq_o` bit is low. Address 7 and any other unmapped word reads 0.
- R2: Control bit 29 is interrupt enable, bit 30 is count enable and bit 31 is debug enable. The other control bits read 0. A channel runs only when all three bits are 1.
- R3: A control write that takes a stopped channel to running copies the initial count into the live count.
- R4: While running, the live count decrements by one on each cycle with `tick_i` high. It is unchanged in cycles without a tick.
- R5: A tick with the live count at 0 reloads the initial count and sets that channel's status bit, where status bit i belongs to channel i. The period is initial count + 1 ticks.
- R6: A write to the initial count is ignored while the channel runs and takes effect while it is stopped.
- R7: The live count is host readable and writable. A host write in the same cycle as a tick wins.
- R8: Clearing the count-enable bit stops the channel and holds its live count through later ticks.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A reload in the same cycle as the clear keeps the bit set.
- R10: `irq_o[i]` is high exactly while status bit i and channel i's interrupt-enable bit are both 1. Channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count strobe, one decrement per high cycle |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2+CH_W | Word address: region above channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | NUM_CH | Per-channel interrupt level |

## Verification
The assertions assume that `tick_i` and bus inputs are stable around the clock edge and that at most one register is written per cycle. The stimulus keeps to this by changing inputs only on the falling edge, with one access per bus task. They also assume that a running channel's control word is rewritten only to stop it. The directed scenarios never rewrite a running channel's control word with all three enables still set. Ticks and host writes are made to collide deliberately only for the live count and the status register, where the requirements define the winner.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int DATA_W  = 32;
    localparam int BIT_IE  = 29;
    localparam int BIT_CEN = 30;
    localparam int BIT_DBG = 31;

    typedef struct packed {
        logic dbg;
        logic cen;
        logic ie;
    } ctrl_t;

    typedef enum logic [1:0] {
        RG_CTRL  = 2'd0,
        RG_INIT  = 2'd1,
        RG_COUNT = 2'd2,
        RG_STAT  = 2'd3
    } region_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ie  = w[BIT_IE];
        c.cen = w[BIT_CEN];
        c.dbg = w[BIT_DBG];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[BIT_IE]  = c.ie;
        w[BIT_CEN] = c.cen;
        w[BIT_DBG] = c.dbg;
        return w;
    endfunction

    function automatic logic ctrl_runs(input ctrl_t c);
        return c.ie & c.cen & c.dbg;
    endfunction

endpackage

// File: rtl/itmr_chan.sv
module itmr_chan
    import itmr_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wdata,
    input  logic             init_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] val_wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] init_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_o,
    output logic             reload_o
);

    logic start;
    logic at_zero;

    assign run_o    = ctrl_runs(ctrl_q);
    assign start    = ctrl_we && !run_o && ctrl_runs(ctrl_wdata);
    assign at_zero  = (cnt_q == '0);
    assign reload_o = run_o && tick_i && at_zero && !cnt_we;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            init_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= ctrl_wdata;
            if (init_we && !run_o)
                init_q <= val_wdata;
            if (start)
                cnt_q <= init_q;
            else if (cnt_we)
                cnt_q <= val_wdata;
            else if (run_o && tick_i)
                cnt_q <= at_zero ? init_q : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/itmr_status.sv
module itmr_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] stat_q
);

    logic [NUM_CH-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_eff) | set_i;
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 29,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = 2 + CH_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    region_t           region;
    logic [CH_W-1:0]   ch_sel;
    logic              wr;
    logic              stat_we;

    logic [NUM_CH-1:0]            ch_ctrl_we;
    logic [NUM_CH-1:0]            ch_init_we;
    logic [NUM_CH-1:0]            ch_cnt_we;
    logic [NUM_CH-1:0]            ch_run;
    logic [NUM_CH-1:0]            ch_ie;
    logic [NUM_CH-1:0]            ch_reload;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_init;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    ctrl_t [NUM_CH-1:0]           ch_ctrl;
    logic [NUM_CH-1:0]            stat_q;

    assign region  = region_t'(bus_addr[ADDR_W-1:CH_W]);
    assign ch_sel  = bus_addr[CH_W-1:0];
    assign wr      = bus_sel && bus_we;
    assign stat_we = wr && (region == RG_STAT) && (ch_sel == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit           = wr && (ch_sel == CH_W'(i));
        assign ch_ctrl_we[i] = hit && (region == RG_CTRL);
        assign ch_init_we[i] = hit && (region == RG_INIT);
        assign ch_cnt_we[i]  = hit && (region == RG_COUNT);
        assign ch_ie[i]      = ch_ctrl[i].ie;

        itmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .tick_i     (tick_i),
            .ctrl_we    (ch_ctrl_we[i]),
            .ctrl_wdata (ctrl_from_word(bus_wdata)),
            .init_we    (ch_init_we[i]),
            .cnt_we     (ch_cnt_we[i]),
            .val_wdata  (bus_wdata[CNT_W-1:0]),
            .ctrl_q     (ch_ctrl[i]),
            .init_q     (ch_init[i]),
            .cnt_q      (ch_cnt[i]),
            .run_o      (ch_run[i]),
            .reload_o   (ch_reload[i])
        );
    end

    itmr_status #(.NUM_CH(NUM_CH)) u_status (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .set_i    (ch_reload),
        .clr_we   (stat_we),
        .clr_mask (bus_wdata[NUM_CH-1:0]),
        .stat_q   (stat_q)
    );

    assign irq_o = stat_q & ch_ie;

    always_comb begin
        bus_rdata = '0;
        if (region == RG_STAT) begin
            if (ch_sel == '0)
                bus_rdata[NUM_CH-1:0] = stat_q;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == CH_W'(i)) begin
                    case (region)
                        RG_CTRL:  bus_rdata = ctrl_to_word(ch_ctrl[i]);
                        RG_INIT:  bus_rdata = DATA_W'(ch_init[i]);
                        RG_COUNT: bus_rdata = DATA_W'(ch_cnt[i]);
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 29
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          tick_i,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic                          stat_we,
    input logic [NUM_CH-1:0]             ch_ctrl_we,
    input logic [NUM_CH-1:0]             ch_init_we,
    input logic [NUM_CH-1:0]             ch_cnt_we,
    input logic [NUM_CH-1:0]             ch_run,
    input logic [NUM_CH-1:0]             ch_ie,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_init,
    input logic [NUM_CH-1:0]             stat_q,
    input logic [NUM_CH-1:0]             irq_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R3
        start_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ch_ctrl_we[i] && !ch_run[i] && (&bus_wdata[BIT_DBG:BIT_IE])
            |=> ch_run[i] && ch_cnt[i] == $past(ch_init[i]));

        // R4
        decrement_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ch_run[i] && tick_i && !ch_cnt_we[i] && ch_cnt[i] != '0
            |=> ch_cnt[i] == $past(ch_cnt[i]) - 1'b1);

        // R5
        reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ch_run[i] && tick_i && !ch_cnt_we[i] && ch_cnt[i] == '0
            |=> ch_cnt[i] == $past(ch_init[i]) && stat_q[i]);

        // R6
        init_locked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ch_init_we[i] && ch_run[i] |=> $stable(ch_init[i]));

        // R8
        hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !ch_run[i] && !ch_cnt_we[i] && !ch_ctrl_we[i] |=> $stable(ch_cnt[i]));

        // R9
        clear_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(stat_q[i]) |-> $past(stat_we && bus_wdata[i]));

        // R10
        irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            irq_o[i] |-> stat_q[i] && ch_ie[i]);
    end

endmodule

bind interval_timer interval_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .bus_wdata  (bus_wdata),
    .stat_we    (stat_we),
    .ch_ctrl_we (ch_ctrl_we),
    .ch_init_we (ch_init_we),
    .ch_cnt_we  (ch_cnt_we),
    .ch_run     (ch_run),
    .ch_ie      (ch_ie),
    .ch_cnt     (ch_cnt),
    .ch_init    (ch_init),
    .stat_q     (stat_q),
    .irq_o      (irq_o)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;

    localparam int NUM_CH = 2;
    localparam int AW     = 3;

    localparam logic [AW-1:0] A_CTRL0 = 3'd0, A_CTRL1 = 3'd1;
    localparam logic [AW-1:0] A_INIT0 = 3'd2, A_INIT1 = 3'd3;
    localparam logic [AW-1:0] A_CNT0  = 3'd4, A_CNT1  = 3'd5;
    localparam logic [AW-1:0] A_STAT  = 3'd6, A_NONE  = 3'd7;

    localparam logic [31:0] RUN_ALL = 32'hE000_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic              sel;
    logic              we;
    logic [AW-1:0]     addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] irq;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    interval_timer u_interval_timer (
        .clk_i     (clk),
        .rst_i     (rst),
        .tick_i    (tick),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1;
        chk(tag, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl0", A_CTRL0, 0);
        rd_chk("R1 init1", A_INIT1, 0);
        rd_chk("R1 cnt0", A_CNT0, 0);
        rd_chk("R1 stat", A_STAT, 0);
        rd_chk("R1 unmapped", A_NONE, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_enable_bits;
        wr(A_CTRL0, 32'h1FFF_FFFF);
        rd_chk("R2 low bits masked", A_CTRL0, 0);
        wr(A_INIT0, 5);
        wr(A_CTRL0, 32'h6000_0000);
        rd_chk("R2 ctrl readback", A_CTRL0, 32'h6000_0000);
        ticks(3);
        rd_chk("R2 two of three bits: no run", A_CNT0, 0);
        wr(A_CTRL0, 0);
    endtask

    task automatic t_start_count;
        wr(A_CTRL0, RUN_ALL);
        rd_chk("R3 loaded on start", A_CNT0, 5);
        ticks(2);
        rd_chk("R4 two ticks", A_CNT0, 3);
        repeat (3) @(negedge clk);
        rd_chk("R4 no tick no change", A_CNT0, 3);
    endtask

    task automatic t_reload;
        ticks(3);
        rd_chk("R5 at zero", A_CNT0, 0);
        rd_chk("R5 no status before wrap", A_STAT, 0);
        ticks(1);
        rd_chk("R5 reload value", A_CNT0, 5);
        rd_chk("R5 status set", A_STAT, 1);
        chk("R10 irq0 high", 32'(irq), 1);
    endtask

    task automatic t_clear;
        wr(A_STAT, 2);
        rd_chk("R9 zero bit leaves status", A_STAT, 1);
        wr(A_STAT, 1);
        rd_chk("R9 one clears", A_STAT, 0);
        chk("R10 irq follows clear", 32'(irq), 0);
    endtask

    task automatic t_init_lock;
        wr(A_INIT0, 9);
        rd_chk("R6 init ignored while running", A_INIT0, 5);
        wr(A_CTRL0, 32'hA000_0000);
        ticks(3);
        rd_chk("R8 count held when stopped", A_CNT0, 5);
        wr(A_INIT0, 9);
        rd_chk("R6 init taken while stopped", A_INIT0, 9);
        wr(A_CTRL0, RUN_ALL);
        rd_chk("R3 restart loads new init", A_CNT0, 9);
    endtask

    task automatic t_host_count;
        wr(A_CNT0, 2);
        rd_chk("R7 host write", A_CNT0, 2);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; we = 1'b1; addr = A_CNT0; wdata = 7;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; we = 1'b0;
        rd_chk("R7 host beats tick", A_CNT0, 7);
    endtask

    task automatic t_second_channel;
        wr(A_INIT1, 0);
        wr(A_CTRL1, RUN_ALL);
        ticks(1);
        rd_chk("R5 zero period reload", A_CNT1, 0);
        rd_chk("R10 only bit1 set", A_STAT, 2);
        chk("R10 only irq1", 32'(irq), 2);
        rd_chk("R4 ch0 independent", A_CNT0, 6);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; we = 1'b1; addr = A_STAT; wdata = 2;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; we = 1'b0;
        rd_chk("R9 set beats clear", A_STAT, 2);
        wr(A_CTRL1, 32'hC000_0000);
        chk("R10 ie off masks irq", 32'(irq), 0);
        rd_chk("R10 status kept", A_STAT, 2);
        wr(A_STAT, 2);
        rd_chk("R9 cleared bit1", A_STAT, 0);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_bits();
        t_start_count();
        t_reload();
        t_clear();
        t_init_lock();
        t_host_count();
        t_second_channel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule